// File: doc/BRIEF.md
# Configuration Bank Data Loader

This block takes one burst of configuration payload and turns it into single-bit writes aimed at one memory bank. A start strobe captures the window geometry: column count, row count, the first row to fill, the bank index and whether the target is a configuration bank or a block-RAM bank. After the strobe, the block accepts data bytes through a valid/ready byte port. Each byte is spread over eight consecutive clock cycles, most significant bit first. Bit addresses walk the window row by row.

When the window is full, the block expects two more bytes, and both must be zero. It then reports either a one-cycle done pulse or a one-cycle trailer error pulse, and returns to idle. Because the first written row is the captured offset, a tall bank can be filled in several passes, each pass with a reduced row count.

Command decoding ahead of the loader and the memories behind it are separate blocks. A start strobe that arrives while a burst is running is discarded and reported.

Top module: `cfg_bank_loader`

## Requirements
- R1: After reset, byte_ready_o, wr_en_o, done_o, trailer_err_o and busy_err_o are all 0. A start_i seen in idle captures the geometry, and byte_ready_o is 1 in the following cycle.
- R2: Each accepted byte produces exactly eight cycles with wr_en_o=1, carrying byte bit 7 first and bit 0 last. byte_ready_o is 0 in every one of those cycles.
- R3: The write for bit index k of the burst (counted from 0 in arrival order) has wr_col_o = k mod width and wr_row_o = (offset + k div width) mod 2^COORD_W.
- R4: Every write of a burst carries the captured bank index on wr_bank_o and the captured target type on wr_bram_o (1 = block-RAM bank, 0 = configuration bank).
- R5: A burst emits exactly width*height writes before the block switches to collecting the trailer. If width or height is 0, the block emits no write and goes straight to the trailer.
- R6: If both trailer bytes are 0x00, done_o is 1 for exactly the one cycle after the second trailer byte is accepted.
- R7: If either trailer byte is nonzero, trailer_err_o is 1 for exactly that cycle instead, and done_o stays 0.
- R8: A start_i outside idle is ignored: busy_err_o is 1 in the next cycle, and the running burst keeps its geometry, bank and addresses.
- R9: In idle, byte_ready_o is 0, so no byte is accepted between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst with the cfg_* values |
| cfg_width_i | input | COORD_W | Columns per row |
| cfg_height_i | input | COORD_W | Rows in this pass |
| cfg_offset_i | input | COORD_W | First row written |
| cfg_bank_i | input | BANK_W | Bank index |
| cfg_bram_i | input | 1 | 1 = block-RAM bank, 0 = configuration bank |
| byte_valid_i | input | 1 | Byte present |
| byte_i | input | BYTE_W | Data or trailer byte |
| byte_ready_o | output | 1 | Byte is accepted at this edge when valid |
| wr_en_o | output | 1 | Bit write strobe |
| wr_bram_o | output | 1 | Target type of the write |
| wr_bank_o | output | BANK_W | Bank index of the write |
| wr_row_o | output | COORD_W | Row address |
| wr_col_o | output | COORD_W | Column address |
| wr_bit_o | output | 1 | Bit value |
| done_o | output | 1 | Burst ended with a clean trailer |
| trailer_err_o | output | 1 | Burst ended with a nonzero trailer byte |
| busy_err_o | output | 1 | A start strobe was dropped |

## Verification
The first write of a byte appears in the cycle right after the byte is accepted, and the next seven follow without a gap. The bench therefore checks the write port at every falling edge while wr_en_o is high, and compares it with the bit index that the bench counts itself. The done or trailer-error pulse, the busy pulse and the rise of byte_ready_o after start are all due one cycle after the edge that caused them. Each of these is sampled at the falling edge that follows that edge. Geometries are swept across all widths from 1 to 8, plus wrapped offsets, an empty window and both trailer outcomes.

// File: rtl/cfg_bank_loader_pkg.sv
package cfg_bank_loader_pkg;
   typedef enum logic [1:0] {
      LD_IDLE  = 2'd0,
      LD_DATA  = 2'd1,
      LD_TRAIL = 2'd2
   } ld_state_e;
endpackage

// File: rtl/cfg_bit_serializer.sv
// Shifts one byte out, one bit per cycle, most significant bit first.
module cfg_bit_serializer #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [BYTE_W-1:0] din,
   output logic              active_o,
   output logic              bit_o
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   logic [BYTE_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= din;
         cnt_q <= CNT_W'(BYTE_W);
      end else if (cnt_q != '0) begin
         sh_q  <= sh_q << 1;
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign active_o = (cnt_q != '0);
   assign bit_o    = sh_q[BYTE_W-1];
endmodule

// File: rtl/cfg_raster_walker.sv
// Row-major address walk over a width x height window starting at a row offset.
module cfg_raster_walker #(
   parameter int COORD_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init,
   input  logic               step,
   input  logic [COORD_W-1:0] width_i,
   input  logic [COORD_W-1:0] height_i,
   input  logic [COORD_W-1:0] offset_i,
   output logic [COORD_W-1:0] row_o,
   output logic [COORD_W-1:0] col_o,
   output logic               last_o
);
   logic [COORD_W-1:0] r_q, c_q;
   logic               col_end;

   assign col_end = (c_q == width_i - COORD_W'(1));
   assign last_o  = col_end && (r_q == height_i - COORD_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_q <= '0;
         c_q <= '0;
      end else if (init) begin
         r_q <= '0;
         c_q <= '0;
      end else if (step) begin
         if (col_end) begin
            c_q <= '0;
            r_q <= r_q + COORD_W'(1);
         end else begin
            c_q <= c_q + COORD_W'(1);
         end
      end
   end

   assign row_o = offset_i + r_q;
   assign col_o = c_q;
endmodule

// File: rtl/cfg_trailer_check.sv
// Counts the trailer bytes and issues a registered done or error pulse after the last one.
module cfg_trailer_check #(
   parameter int BYTE_W    = 8,
   parameter int TRAIL_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              take,
   input  logic [BYTE_W-1:0] din,
   output logic              end_o,
   output logic              done_o,
   output logic              err_o
);
   localparam int CNT_W = (TRAIL_LEN > 1) ? $clog2(TRAIL_LEN) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             bad_q, bad_all, done_q, err_q;

   assign bad_all = bad_q | (|din);
   assign end_o   = take && (cnt_q == CNT_W'(TRAIL_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         bad_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (arm) begin
            cnt_q <= '0;
            bad_q <= 1'b0;
         end else if (end_o) begin
            done_q <= !bad_all;
            err_q  <= bad_all;
            cnt_q  <= '0;
            bad_q  <= 1'b0;
         end else if (take) begin
            cnt_q <= cnt_q + CNT_W'(1);
            bad_q <= bad_all;
         end
      end
   end

   assign done_o = done_q;
   assign err_o  = err_q;
endmodule

// File: rtl/cfg_bank_loader.sv
module cfg_bank_loader
   import cfg_bank_loader_pkg::*;
#(
   parameter int COORD_W   = 16,
   parameter int NUM_BANKS = 4,
   parameter int BYTE_W    = 8,
   parameter int TRAIL_LEN = 2,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [COORD_W-1:0] cfg_width_i,
   input  logic [COORD_W-1:0] cfg_height_i,
   input  logic [COORD_W-1:0] cfg_offset_i,
   input  logic [BANK_W-1:0]  cfg_bank_i,
   input  logic               cfg_bram_i,
   input  logic               byte_valid_i,
   input  logic [BYTE_W-1:0]  byte_i,
   output logic               byte_ready_o,
   output logic               wr_en_o,
   output logic               wr_bram_o,
   output logic [BANK_W-1:0]  wr_bank_o,
   output logic [COORD_W-1:0] wr_row_o,
   output logic [COORD_W-1:0] wr_col_o,
   output logic               wr_bit_o,
   output logic               done_o,
   output logic               trailer_err_o,
   output logic               busy_err_o
);
   // elaboration-time parameter checks
   if (COORD_W < 2 || COORD_W > 32) begin : g_bad_coord
      $error("COORD_W must lie in 2..32");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("NUM_BANKS must be at least 1");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must be at least 2");
   end
   if (TRAIL_LEN < 1) begin : g_bad_trail
      $error("TRAIL_LEN must be at least 1");
   end

   ld_state_e          state_q;
   logic [COORD_W-1:0] geo_w_q, geo_h_q, geo_off_q;
   logic               bram_q, busy_q;
   logic [BANK_W-1:0]  bank_q;
   logic               idle, start_take, accept;
   logic               ser_active, ser_bit, walk_last, tr_end;

   assign idle       = (state_q == LD_IDLE);
   assign start_take = start_i && idle;
   assign accept     = byte_valid_i && byte_ready_o;

   assign byte_ready_o = ((state_q == LD_DATA) && !ser_active) || (state_q == LD_TRAIL);
   assign wr_en_o      = (state_q == LD_DATA) && ser_active;

   if (NUM_BANKS > 1) begin : g_bank_reg
      always_ff @(posedge clk) begin
         if (!rst_n)          bank_q <= '0;
         else if (start_take) bank_q <= cfg_bank_i;
      end
   end else begin : g_bank_fixed
      assign bank_q = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= LD_IDLE;
         geo_w_q   <= '0;
         geo_h_q   <= '0;
         geo_off_q <= '0;
         bram_q    <= 1'b0;
         busy_q    <= 1'b0;
      end else begin
         busy_q <= start_i && !idle;
         unique case (state_q)
            LD_IDLE: if (start_i) begin
               geo_w_q   <= cfg_width_i;
               geo_h_q   <= cfg_height_i;
               geo_off_q <= cfg_offset_i;
               bram_q    <= cfg_bram_i;
               state_q   <= (cfg_width_i == '0 || cfg_height_i == '0) ? LD_TRAIL : LD_DATA;
            end
            LD_DATA:  if (wr_en_o && walk_last) state_q <= LD_TRAIL;
            LD_TRAIL: if (tr_end) state_q <= LD_IDLE;
            default:  state_q <= LD_IDLE;
         endcase
      end
   end

   cfg_bit_serializer #(.BYTE_W(BYTE_W)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (state_q != LD_DATA),
      .load     ((state_q == LD_DATA) && accept),
      .din      (byte_i),
      .active_o (ser_active),
      .bit_o    (ser_bit)
   );

   cfg_raster_walker #(.COORD_W(COORD_W)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (start_take),
      .step     (wr_en_o),
      .width_i  (geo_w_q),
      .height_i (geo_h_q),
      .offset_i (geo_off_q),
      .row_o    (wr_row_o),
      .col_o    (wr_col_o),
      .last_o   (walk_last)
   );

   cfg_trailer_check #(.BYTE_W(BYTE_W), .TRAIL_LEN(TRAIL_LEN)) u_trail (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (start_take),
      .take   ((state_q == LD_TRAIL) && accept),
      .din    (byte_i),
      .end_o  (tr_end),
      .done_o (done_o),
      .err_o  (trailer_err_o)
   );

   assign wr_bit_o   = ser_bit;
   assign wr_bank_o  = bank_q;
   assign wr_bram_o  = bram_q;
   assign busy_err_o = busy_q;
endmodule

// File: rtl/cfg_bank_loader_chk.sv
module cfg_bank_loader_chk #(
   parameter int COORD_W = 16,
   parameter int BANK_W  = 2,
   parameter int BYTE_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               idle_i,
   input logic               start_i,
   input logic               byte_valid_i,
   input logic [BYTE_W-1:0]  byte_i,
   input logic               byte_ready_o,
   input logic               wr_en_o,
   input logic               wr_bram_o,
   input logic [BANK_W-1:0]  wr_bank_o,
   input logic [COORD_W-1:0] wr_row_o,
   input logic [COORD_W-1:0] wr_col_o,
   input logic [COORD_W-1:0] geo_w_i,
   input logic [COORD_W-1:0] geo_h_i,
   input logic [COORD_W-1:0] geo_off_i,
   input logic               done_o,
   input logic               trailer_err_o,
   input logic               busy_err_o
);
   logic [COORD_W-1:0] rel_row;
   assign rel_row = wr_row_o - geo_off_i;

   p_ready_off_while_writing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> !byte_ready_o);

   p_col_in_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_col_o < geo_w_i));

   p_row_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (rel_row < geo_h_i));

   p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && $past(wr_en_o) && wr_col_o != '0) |-> (wr_col_o == $past(wr_col_o) + COORD_W'(1)));

   p_bank_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && $past(wr_en_o)) |-> ($stable(wr_bank_o) && $stable(wr_bram_o)));

   p_done_on_zero_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(byte_valid_i && byte_ready_o && byte_i == '0));

   p_single_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && trailer_err_o));

   p_busy_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !idle_i) |=> busy_err_o);

   p_no_take_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idle_i |-> (!byte_ready_o && !wr_en_o));
endmodule

bind cfg_bank_loader cfg_bank_loader_chk #(
   .COORD_W (COORD_W),
   .BANK_W  (BANK_W),
   .BYTE_W  (BYTE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .idle_i        (idle),
   .start_i       (start_i),
   .byte_valid_i  (byte_valid_i),
   .byte_i        (byte_i),
   .byte_ready_o  (byte_ready_o),
   .wr_en_o       (wr_en_o),
   .wr_bram_o     (wr_bram_o),
   .wr_bank_o     (wr_bank_o),
   .wr_row_o      (wr_row_o),
   .wr_col_o      (wr_col_o),
   .geo_w_i       (geo_w_q),
   .geo_h_i       (geo_h_q),
   .geo_off_i     (geo_off_q),
   .done_o        (done_o),
   .trailer_err_o (trailer_err_o),
   .busy_err_o    (busy_err_o)
);

// File: tb/cfg_bank_loader_test.sv
`timescale 1ns/1ps
module cfg_bank_loader_test;
   localparam int CW = 8;
   localparam int BW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [CW-1:0] cfg_width_i = '0, cfg_height_i = '0, cfg_offset_i = '0;
   logic [BW-1:0] cfg_bank_i = '0;
   logic          cfg_bram_i = 1'b0;
   logic          byte_valid_i = 1'b0;
   logic [7:0]    byte_i = '0;
   logic          byte_ready_o, wr_en_o, wr_bram_o, wr_bit_o;
   logic [BW-1:0] wr_bank_o;
   logic [CW-1:0] wr_row_o, wr_col_o;
   logic          done_o, trailer_err_o, busy_err_o;

   int errors = 0;
   int checks = 0;

   // expectations for the running burst
   int exp_w, exp_off, exp_bank, exp_bram, exp_seed;
   int wr_cnt = 0;

   always #2 clk = ~clk;

   cfg_bank_loader #(.COORD_W(CW), .NUM_BANKS(4), .BYTE_W(8), .TRAIL_LEN(2)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .cfg_width_i(cfg_width_i), .cfg_height_i(cfg_height_i), .cfg_offset_i(cfg_offset_i),
      .cfg_bank_i(cfg_bank_i), .cfg_bram_i(cfg_bram_i),
      .byte_valid_i(byte_valid_i), .byte_i(byte_i), .byte_ready_o(byte_ready_o),
      .wr_en_o(wr_en_o), .wr_bram_o(wr_bram_o), .wr_bank_o(wr_bank_o),
      .wr_row_o(wr_row_o), .wr_col_o(wr_col_o), .wr_bit_o(wr_bit_o),
      .done_o(done_o), .trailer_err_o(trailer_err_o), .busy_err_o(busy_err_o)
   );

   function automatic logic [7:0] pat(int s, int i);
      return 8'((i * 53 + s * 29 + 7) ^ (i << 3));
   endfunction

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // write-port monitor: every write is compared with the arithmetic expectation
   always @(negedge clk) begin
      if (rst_n && wr_en_o) begin
         automatic int k = wr_cnt;
         automatic logic [7:0] b = pat(exp_seed, k / 8);
         automatic int ebit = int'(b[7 - (k % 8)]);
         automatic int ecol = k % exp_w;
         automatic int erow = (exp_off + k / exp_w) % 256;
         check(wr_bit_o == ebit[0], "R2 bit msb-first", int'(wr_bit_o), ebit);
         check(!byte_ready_o, "R2 ready low while writing", int'(byte_ready_o), 0);
         check(int'(wr_col_o) == ecol, "R3 column", int'(wr_col_o), ecol);
         check(int'(wr_row_o) == erow, "R3 row", int'(wr_row_o), erow);
         check(int'(wr_bank_o) == exp_bank && int'(wr_bram_o) == exp_bram, "R4 bank/type",
               int'(wr_bank_o) * 2 + int'(wr_bram_o), exp_bank * 2 + exp_bram);
         wr_cnt++;
      end
   end

   // call at a falling edge; returns at the falling edge after acceptance
   task automatic send(input logic [7:0] b);
      byte_i = b;
      byte_valid_i = 1'b1;
      while (!byte_ready_o) @(negedge clk);
      @(negedge clk);
      byte_valid_i = 1'b0;
   endtask

   task automatic run(input int w, input int h, input int off, input int bank, input int bram,
                      input int seed, input logic [7:0] t0, input logic [7:0] t1, input bit inject);
      int nbytes = (w * h) / 8;
      logic clean = (t0 == 8'h00) && (t1 == 8'h00);
      exp_w = w; exp_off = off; exp_bank = bank; exp_bram = bram; exp_seed = seed;
      wr_cnt = 0;
      check(!byte_ready_o, "R9 no byte taken in idle", int'(byte_ready_o), 0);
      cfg_width_i = CW'(w); cfg_height_i = CW'(h); cfg_offset_i = CW'(off);
      cfg_bank_i = BW'(bank); cfg_bram_i = bram[0];
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(byte_ready_o, "R1 ready after start", int'(byte_ready_o), 1);
      for (int i = 0; i < nbytes; i++) begin
         send(pat(seed, i));
         if (inject && i == 0) begin
            cfg_width_i = 8'd3; cfg_height_i = 8'd1; cfg_offset_i = 8'd99;
            cfg_bank_i = BW'(bank + 1); cfg_bram_i = ~bram[0];
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_err_o, "R8 busy flag", int'(busy_err_o), 1);
         end
      end
      send(t0);
      send(t1);
      check(wr_cnt == w * h, "R5 write count", wr_cnt, w * h);
      check(done_o == clean, "R6 done pulse", int'(done_o), int'(clean));
      check(trailer_err_o == !clean, "R7 trailer error", int'(trailer_err_o), int'(!clean));
      @(negedge clk);
      check(!done_o && !trailer_err_o, "R6 pulse one cycle", int'(done_o) + int'(trailer_err_o), 0);
      check(!byte_ready_o, "R9 idle after burst", int'(byte_ready_o), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!byte_ready_o && !wr_en_o && !done_o && !trailer_err_o && !busy_err_o,
            "R1 reset state", int'(byte_ready_o) + int'(wr_en_o) + int'(done_o), 0);
      // stray byte in idle must not be taken (R9)
      byte_i = 8'hA5; byte_valid_i = 1'b1;
      @(negedge clk);
      check(!byte_ready_o && !wr_en_o, "R9 stray byte ignored", int'(wr_en_o), 0);
      byte_valid_i = 1'b0;

      run(8, 2, 0, 0, 0, 1, 8'h00, 8'h00, 1'b0);
      run(4, 6, 3, 2, 1, 2, 8'h00, 8'h5A, 1'b1);    // R8 busy start mid-burst, R7
      run(12, 2, 255, 1, 0, 3, 8'h00, 8'h00, 1'b0); // R3 row wrap
      run(0, 5, 9, 3, 1, 4, 8'h01, 8'h00, 1'b0);    // R5 empty window, R7
      run(1, 8, 7, 3, 0, 5, 8'h00, 8'h00, 1'b0);
      for (int w = 1; w <= 8; w++) begin
         run(w, 8, w * 3, w % 4, w % 2, 10 + w, 8'h00, (w == 5) ? 8'h80 : 8'h00, w == 6);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule